// File: doc/BRIEF.md
# Breakpoint Halt and Run-Interval Cycle Counter

This block sits in the debug unit of a small 8-bit processor. The processor raises a one-cycle strobe when it decodes the all-zero opcode, which is the break instruction. An erased-and-programmed flash byte reads as all zeros, so a breakpoint is planted by writing that value over an instruction. The block checks its breakpoint-enable input when the strobe arrives. If breakpoints are enabled, it moves into a halted debug state and asks the processor to idle. If they are disabled, the strobe is dropped and the instruction completes as a no-operation.

A cycle counter runs alongside the halt logic and measures how long the processor ran between halts. It clears to zero when a debug-exit command releases the processor. It then adds one on every system clock edge spent in run mode. It freezes on entry to debug mode, so the host can read it while halted. The counter holds at its all-ones value rather than wrapping. Reset places the block in run mode with the counter at zero, as if an exit had just happened.

Top module: `dbg_runtime_top`

## Requirements
- R1: After reset, debug_mode_o and cpu_idle_o are 0 and runtime_o is 0.
- R2: In run mode, a clock edge with brk_decoded_i=1 and brk_enable_i=1 puts the block in debug mode; debug_mode_o is 1 from that edge on.
- R3: In run mode, brk_decoded_i=1 with brk_enable_i=0 is ignored: the block stays in run mode and the counter keeps counting.
- R4: Every clock edge that finds the block in run mode (debug_mode_o=0) adds one to runtime_o, including the edge that enters debug mode.
- R5: A clock edge with debug_exit_i=1 in debug mode returns the block to run mode and sets runtime_o to 0. This takes priority over a break strobe on the same edge.
- R6: In debug mode, runtime_o holds its value, and a further break strobe has no effect.
- R7: runtime_o stops at 2^CNT_W-1 (FFFFH at the default width of 16) and stays there until the next exit from debug mode.
- R8: debug_exit_i in run mode is ignored: the counter is not cleared and the mode does not change.
- R9: cpu_idle_o equals debug_mode_o on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| brk_decoded_i | input | 1 | Processor decoded the break opcode this cycle |
| brk_enable_i | input | 1 | Breakpoints enabled |
| debug_exit_i | input | 1 | Host command to leave debug mode |
| debug_mode_o | output | 1 | Block is in debug mode |
| cpu_idle_o | output | 1 | Request for the processor to idle |
| runtime_o | output | CNT_W | Run-interval cycle count |

## Verification
The assertions check the following on every cycle:
- the step from run to debug mode on an enabled strobe;
- the rejection of a disabled strobe;
- the one-per-edge increment and the hold at the all-ones value;
- the hold of the count while halted;
- the clear on exit;
- the match between the idle request and the mode.

Only the bench's scenarios can show that whole intervals come out right. It sweeps interval lengths from zero upward and checks the count read after each halt. It also checks the simultaneous strobe-and-exit case and a full run of more than 65535 cycles up to saturation.

// File: rtl/dbg_runtime_pkg.sv
package dbg_runtime_pkg;
    typedef enum logic {
        MODE_RUN   = 1'b0,
        MODE_DEBUG = 1'b1
    } mode_e;

    typedef struct packed {
        mode_e mode;
    } mode_state_t;
endpackage

// File: rtl/dbg_mode_fsm.sv
module dbg_mode_fsm
    import dbg_runtime_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic brk_i,
    input  logic brk_en_i,
    input  logic exit_i,
    output logic debug_o,
    output logic clear_o
);
    mode_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        clear_o = 1'b0;
        unique case (st_q.mode)
            MODE_RUN: begin
                if (brk_i && brk_en_i) st_d.mode = MODE_DEBUG;
            end
            MODE_DEBUG: begin
                if (exit_i) begin
                    st_d.mode = MODE_RUN;
                    clear_o   = 1'b1;
                end
            end
            default: st_d.mode = MODE_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: MODE_RUN};
        else        st_q <= st_d;
    end

    assign debug_o = (st_q.mode == MODE_DEBUG);
endmodule

// File: rtl/dbg_run_counter.sv
module dbg_run_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             clear_i,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (clear_i)
            c_d.cnt = '0;
        else if (run_i && (c_q.cnt != CNT_MAX))
            c_d.cnt = c_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{cnt: '0};
        else        c_q <= c_d;
    end

    assign count_o = c_q.cnt;
endmodule

// File: rtl/dbg_runtime_top.sv
module dbg_runtime_top #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             brk_decoded_i,
    input  logic             brk_enable_i,
    input  logic             debug_exit_i,
    output logic             debug_mode_o,
    output logic             cpu_idle_o,
    output logic [CNT_W-1:0] runtime_o
);
    logic in_debug;
    logic exit_clear;

    dbg_mode_fsm u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .brk_i    (brk_decoded_i),
        .brk_en_i (brk_enable_i),
        .exit_i   (debug_exit_i),
        .debug_o  (in_debug),
        .clear_o  (exit_clear)
    );

    dbg_run_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (!in_debug),
        .clear_i (exit_clear),
        .count_o (runtime_o)
    );

    assign debug_mode_o = in_debug;
    assign cpu_idle_o   = in_debug;
endmodule

// File: rtl/dbg_runtime_chk.sv
module dbg_runtime_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             brk_decoded_i,
    input logic             brk_enable_i,
    input logic             debug_exit_i,
    input logic             debug_mode_o,
    input logic             cpu_idle_o,
    input logic [CNT_W-1:0] runtime_o
);
    localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

    p_enter_on_brk_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!debug_mode_o && brk_decoded_i && brk_enable_i) |=> debug_mode_o);

    p_disabled_brk_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!debug_mode_o && !brk_enable_i) |=> !debug_mode_o);

    p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!debug_mode_o && runtime_o != MAXV) |=> runtime_o == $past(runtime_o) + 1'b1);

    p_exit_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (debug_mode_o && debug_exit_i) |=> (!debug_mode_o && runtime_o == '0));

    p_hold_in_debug_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (debug_mode_o && !debug_exit_i) |=> (debug_mode_o && $stable(runtime_o)));

    p_saturate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!debug_mode_o && runtime_o == MAXV) |=> runtime_o == MAXV);

    p_exit_in_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!debug_mode_o && debug_exit_i && !brk_decoded_i) |=> !debug_mode_o);

    p_idle_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_idle_o == debug_mode_o);
endmodule

bind dbg_runtime_top dbg_runtime_chk #(.CNT_W(CNT_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .brk_decoded_i (brk_decoded_i),
    .brk_enable_i  (brk_enable_i),
    .debug_exit_i  (debug_exit_i),
    .debug_mode_o  (debug_mode_o),
    .cpu_idle_o    (cpu_idle_o),
    .runtime_o     (runtime_o)
);

// File: tb/dbg_runtime_top_tb_top.sv
`timescale 1ns/1ps
module dbg_runtime_top_tb_top;
    localparam int W = 16;
    localparam int MAXV = (1 << W) - 1;

    logic clk = 1'b0;
    logic rst_n;
    logic brk, en, ex;
    logic dbg, idle;
    logic [W-1:0] cnt;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dbg_runtime_top #(.CNT_W(W)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .brk_decoded_i (brk),
        .brk_enable_i  (en),
        .debug_exit_i  (ex),
        .debug_mode_o  (dbg),
        .cpu_idle_o    (idle),
        .runtime_o     (cnt)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input logic b, input logic e, input logic x);
        brk = b; en = e; ex = x;
        @(negedge clk);
        brk = 1'b0; en = 1'b0; ex = 1'b0;
    endtask

    task automatic expect_state(input string req, input int d, input int c);
        check({req, " mode"}, int'(dbg), d);
        check("R9 idle", int'(idle), int'(dbg));
        check({req, " count"}, int'(cnt), c);
    endtask

    initial begin
        brk = 1'b0; en = 1'b0; ex = 1'b0; rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_state("R1", 0, 0);

        for (int i = 1; i <= 3; i++) begin
            tick(0, 0, 0);
            expect_state("R4", 0, i);
        end
        tick(1, 0, 0);
        expect_state("R3", 0, 4);
        tick(0, 0, 1);
        expect_state("R8", 0, 5);
        tick(1, 1, 0);
        expect_state("R2", 1, 6);
        for (int i = 0; i < 4; i++) begin
            tick(0, 0, 0);
            expect_state("R6", 1, 6);
        end
        tick(1, 1, 0);
        expect_state("R6", 1, 6);

        for (int n = 0; n <= 20; n++) begin
            tick(0, 0, 1);
            expect_state("R5", 0, 0);
            for (int k = 0; k < n; k++) tick(0, 0, 0);
            check("R4 interval", int'(cnt), n);
            tick(1, 1, 0);
            expect_state("R2", 1, n + 1);
            tick(0, 1, 0);
            expect_state("R6", 1, n + 1);
        end

        tick(1, 1, 1);
        expect_state("R5", 0, 0);

        for (int k = 0; k < MAXV; k++) tick(0, 0, 0);
        expect_state("R7", 0, MAXV);
        for (int k = 0; k < 3; k++) begin
            tick(0, 0, 0);
            expect_state("R7", 0, MAXV);
        end
        tick(1, 1, 0);
        expect_state("R7", 1, MAXV);
        tick(0, 0, 1);
        expect_state("R5", 0, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #4_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule